// File: doc/BRIEF.md
# Burst Line-Fill Read Sequencer

This block fetches one 16-byte line from an external burst-capable read-only memory. The memory sits on either an 8-bit or a 16-bit data path. A caller offers a start address on a valid/ready request port. The sequencer rounds that address down to the line boundary and drives chip select, the read strobe and an incrementing address. It collects every returned beat into a 128-bit line and raises a one-cycle done pulse with the finished line.

A configuration register chooses the fill shape and the strobe timing. One bit picks between a single long burst and four short bursts. A two-bit field inserts idle cycles between the beats of a burst. Another two-bit field delays the read strobe after chip select, counted in half cycles. The block clock `clk` runs at twice the bus rate, so one edge of `clk` is one half bus cycle. A whole bus cycle is two edges.

Back-pressure rules are as follows. A request is taken on the edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle, so a caller that holds `req_valid` during a fill simply waits. `line_valid` is a pulse with no ready: the consumer must take `line_data` in that cycle.

Top module: `burst_line_fetch`

## Requirements
- R1: The configuration register resets to zero. It keeps only bit 20 (split-burst select), bits 17:16 (inter-beat wait code) and bits 12:11 (strobe-setup code). Every other bit reads as 0 whatever was written.
- R2: With bit 20 clear, a line is read in one burst: 8 beats on the 16-bit path (`bus_wide`=1) and 16 beats on the 8-bit path (`bus_wide`=0). Chip select falls once per line.
- R3: With bit 20 set, a line is read in four bursts of 2 beats (16-bit) or 4 beats (8-bit). Chip select stays high for at least two `clk` edges (one bus cycle) between bursts.
- R4: Wait code w puts 2·w half cycles, with chip select low and the read strobe high, before each beat after the first of a burst.
- R5: Setup code s delays the read strobe by 2·s+1 half cycles after chip select falls. The delay is applied again at the start of every burst.
- R6: Each beat holds the read strobe low for two half cycles. The first address is the request address rounded down to a multiple of 16. Each beat then advances the address by 2 on the 16-bit path and by 1 on the 8-bit path.
- R7: The byte at line offset i equals the memory byte at base+i. A 16-bit beat places `mem_rdata[7:0]` at the lower address. On the 8-bit path, `mem_rdata[15:8]` is ignored.
- R8: `line_valid` is high for exactly one cycle, on the edge after the last beat ends. With N bursts of B beats, that is N·(2s+1+2B+2w(B−1))+2(N−1) edges after the request edge.
- R9: `req_ready` stays low from acceptance until after the done pulse. A request offered during a fill has no effect on that fill.
- R10: After reset, chip select and the read strobe are high (inactive), `req_ready` is high and `line_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle (double bus rate) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write value |
| cfg_rdata | output | 32 | Configuration read value |
| bus_wide | input | 1 | 1 = 16-bit data path, 0 = 8-bit; sampled at request |
| req_valid | input | 1 | Line request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | ADDR_W | Request address (any byte in the line) |
| line_valid | output | 1 | One-cycle done pulse |
| line_data | output | 128 | Assembled line, byte i at bits 8i+7:8i |
| mem_addr | output | ADDR_W | External address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_rdata | input | 16 | External read data |

## Verification
Every timing result is counted in `clk` edges from the edge that takes the request. The bench samples on falling edges and numbers them from the first one after acceptance. So chip select must already be low at sample 1, the read strobe must first fall at sample 2s+2, and `line_valid` must be seen at sample N·(2s+1+2B+2w(B−1))+2(N−1)+1 and be gone at the next one. Per fill, the bench counts the half cycles with the strobe low, the half cycles with chip select low and the strobe high, the chip-select falls and the high run between bursts. It compares each count with its closed form for all 64 combinations of width, split bit, wait code and setup code.

// File: rtl/bfetch_pkg.sv
package bfetch_pkg;

  localparam int CFG_W      = 32;
  localparam int SPLIT_BIT  = 20;
  localparam int WAIT_LSB   = 16;
  localparam int SETUP_LSB  = 11;

  localparam logic [CFG_W-1:0] CFG_KEEP =
      (CFG_W'(1) << SPLIT_BIT) | (CFG_W'(3) << WAIT_LSB) | (CFG_W'(3) << SETUP_LSB);

  typedef struct packed {
    logic       split;
    logic [1:0] wait_code;
    logic [1:0] setup_code;
  } fill_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_BEAT,
    ST_WAIT,
    ST_GAP,
    ST_DONE
  } fill_state_t;

endpackage

// File: rtl/bfetch_cfg.sv
module bfetch_cfg
  import bfetch_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output fill_cfg_t        cfg
);

  logic [CFG_W-1:0] reg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_q <= '0;
    else if (we) reg_q <= wdata & CFG_KEEP;
  end

  assign rdata          = reg_q;
  assign cfg.split      = reg_q[SPLIT_BIT];
  assign cfg.wait_code  = reg_q[WAIT_LSB +: 2];
  assign cfg.setup_code = reg_q[SETUP_LSB +: 2];

  // readback after a write carries only the kept fields
  assert_cfg_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> rdata == ($past(wdata) & CFG_KEEP));

endmodule

// File: rtl/bfetch_seq.sv
module bfetch_seq
  import bfetch_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LINE_BYTES = 16,
  parameter int NUM_SUB    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  fill_cfg_t                     cfg,
  input  logic                          wide_in,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [ADDR_W-1:0]             req_addr,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic                          mem_cs_n,
  output logic                          mem_rd_n,
  output logic                          cap_en,
  output logic [$clog2(LINE_BYTES)-1:0] cap_off,
  output logic                          cap_wide,
  output logic                          done
);

  localparam int OFS_W  = $clog2(LINE_BYTES);
  localparam int CW     = OFS_W + 1;
  localparam int SUB_SH = $clog2(NUM_SUB);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(LINE_BYTES - 1);

  fill_state_t      st;
  fill_cfg_t        cfg_q;
  logic             wide_q;
  logic [2:0]       cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [CW-1:0]    beat_idx;
  logic [CW-1:0]    beat_in_burst;
  logic [CW-1:0]    tot_beats;
  logic [CW-1:0]    sub_beats;
  logic [1:0]       step;
  logic             last_all;
  logic             last_sub;

  always_comb begin
    tot_beats = wide_q ? CW'(LINE_BYTES / 2) : CW'(LINE_BYTES);
    sub_beats = cfg_q.split ? (tot_beats >> SUB_SH) : tot_beats;
    step      = wide_q ? 2'd2 : 2'd1;
    last_all  = (beat_idx == tot_beats - CW'(1));
    last_sub  = (beat_in_burst == sub_beats - CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= ST_IDLE;
      cfg_q         <= '0;
      wide_q        <= 1'b0;
      cnt           <= '0;
      addr_q        <= '0;
      beat_idx      <= '0;
      beat_in_burst <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          st            <= ST_SETUP;
          cfg_q         <= cfg;
          wide_q        <= wide_in;
          cnt           <= {cfg.setup_code, 1'b0};
          addr_q        <= req_addr & ALIGN_MASK;
          beat_idx      <= '0;
          beat_in_burst <= '0;
        end
        ST_SETUP: begin
          if (cnt == 3'd0) begin
            st  <= ST_BEAT;
            cnt <= 3'd1;
          end else cnt <= cnt - 3'd1;
        end
        ST_BEAT: begin
          if (cnt != 3'd0) cnt <= cnt - 3'd1;
          else begin
            addr_q   <= addr_q + {{(ADDR_W-2){1'b0}}, step};
            beat_idx <= beat_idx + CW'(1);
            if (last_all) st <= ST_DONE;
            else if (last_sub) begin
              st            <= ST_GAP;
              cnt           <= 3'd1;
              beat_in_burst <= '0;
            end else begin
              beat_in_burst <= beat_in_burst + CW'(1);
              if (cfg_q.wait_code == 2'd0) begin
                st  <= ST_BEAT;
                cnt <= 3'd1;
              end else begin
                st  <= ST_WAIT;
                cnt <= {cfg_q.wait_code, 1'b0} - 3'd1;
              end
            end
          end
        end
        ST_WAIT: begin
          if (cnt == 3'd0) begin
            st  <= ST_BEAT;
            cnt <= 3'd1;
          end else cnt <= cnt - 3'd1;
        end
        ST_GAP: begin
          if (cnt == 3'd0) begin
            st  <= ST_SETUP;
            cnt <= {cfg_q.setup_code, 1'b0};
          end else cnt <= cnt - 3'd1;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign mem_cs_n  = !(st inside {ST_SETUP, ST_BEAT, ST_WAIT});
  assign mem_rd_n  = (st != ST_BEAT);
  assign mem_addr  = addr_q;
  assign cap_en    = (st == ST_BEAT) && (cnt == 3'd0);
  assign cap_off   = addr_q[OFS_W-1:0];
  assign cap_wide  = wide_q;
  assign done      = (st == ST_DONE);

  // read strobe never falls together with chip select
  assert_setup_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cs_n) |-> mem_rd_n);

  // a beat keeps the strobe low for two half cycles
  assert_beat_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rd_n) |=> !mem_rd_n);

  // chip select high for a full bus cycle once released
  assert_cs_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) |=> mem_cs_n);

  // done is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // no acceptance while the bus is in use
  assert_busy_no_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);

endmodule

// File: rtl/bfetch_line.sv
module bfetch_line #(
  parameter int LINE_BYTES = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cap_en,
  input  logic [$clog2(LINE_BYTES)-1:0] cap_off,
  input  logic                          cap_wide,
  input  logic [15:0]                   rd_data,
  output logic [LINE_BYTES*8-1:0]       line
);

  localparam int OFS_W = $clog2(LINE_BYTES);

  for (genvar i = 0; i < LINE_BYTES; i++) begin : g_lane
    logic take_lo;
    logic take_hi;
    assign take_lo = cap_en && (cap_off == OFS_W'(i));
    if (i > 0) begin : g_hi
      assign take_hi = cap_en && cap_wide && (cap_off == OFS_W'(i - 1));
    end else begin : g_nohi
      assign take_hi = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line[i*8 +: 8] <= '0;
      else if (take_lo) line[i*8 +: 8] <= rd_data[7:0];
      else if (take_hi) line[i*8 +: 8] <= rd_data[15:8];
    end
  end

  // 16-bit beats always land on an even byte offset
  assert_wide_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && cap_wide) |-> !cap_off[0]);

endmodule

// File: rtl/burst_line_fetch.sv
module burst_line_fetch
  import bfetch_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LINE_BYTES = 16,
  parameter int NUM_SUB    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [31:0]             cfg_wdata,
  output logic [31:0]             cfg_rdata,
  input  logic                    bus_wide,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  output logic                    line_valid,
  output logic [LINE_BYTES*8-1:0] line_data,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic                    mem_cs_n,
  output logic                    mem_rd_n,
  input  logic [15:0]             mem_rdata
);

  localparam int OFS_W = $clog2(LINE_BYTES);

  fill_cfg_t        cfg;
  logic             cap_en;
  logic [OFS_W-1:0] cap_off;
  logic             cap_wide;

  bfetch_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg   (cfg)
  );

  bfetch_seq #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .NUM_SUB    (NUM_SUB)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg),
    .wide_in   (bus_wide),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_rd_n  (mem_rd_n),
    .cap_en    (cap_en),
    .cap_off   (cap_off),
    .cap_wide  (cap_wide),
    .done      (line_valid)
  );

  bfetch_line #(
    .LINE_BYTES (LINE_BYTES)
  ) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .cap_off  (cap_off),
    .cap_wide (cap_wide),
    .rd_data  (mem_rdata),
    .line     (line_data)
  );

endmodule

// File: tb/test_burst_line_fetch.sv
`timescale 1ns/1ps
module test_burst_line_fetch;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [31:0]  cfg_wdata = '0;
  logic [31:0]  cfg_rdata;
  logic         bus_wide = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [23:0]  req_addr = '0;
  logic         line_valid;
  logic [127:0] line_data;
  logic [23:0]  mem_addr;
  logic         mem_cs_n;
  logic         mem_rd_n;
  logic [15:0]  mem_rdata;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  burst_line_fetch i_burst_line_fetch (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .bus_wide(bus_wide), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .line_valid(line_valid),
    .line_data(line_data), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_rd_n(mem_rd_n), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return (a[7:0] * 8'd7 + 8'd3) ^ a[15:8];
  endfunction

  always_comb begin
    if (bus_wide) mem_rdata = {mem_byte(mem_addr + 24'd1), mem_byte(mem_addr)};
    else          mem_rdata = {8'hEE, mem_byte(mem_addr)};
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_one(input bit w, input bit sp, input int wc, input int sc,
                         input logic [23:0] a);
    int tot_b, nbur, bb, s_ticks, t_exp;
    int n, falls, first_cs, first_rd, rd_low, cs_only, busy_bad, gap_bad, hi_run;
    bit prev_cs;
    logic [23:0]  base, first_addr;
    logic [127:0] exp_line;

    tot_b   = w ? 8 : 16;
    nbur    = sp ? 4 : 1;
    bb      = tot_b / nbur;
    s_ticks = 2 * sc + 1;
    t_exp   = nbur * (s_ticks + 2 * bb + 2 * wc * (bb - 1)) + 2 * (nbur - 1);
    base    = a & 24'hFFFFF0;
    for (int i = 0; i < 16; i++) exp_line[i*8 +: 8] = mem_byte(base + 24'(i));

    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = (32'(sp) << 20) | (32'(wc) << 16) | (32'(sc) << 11) | 32'h000C_E000;
    @(negedge clk);
    cfg_we    = 1'b0;
    chk(req_ready == 1'b1, "R9 ready when idle", 128'(req_ready), 128'd1);
    bus_wide  = w;
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_addr  = a ^ 24'h000FF0;   // competing request held during the fill (R9)

    n = 1; falls = 0; first_cs = -1; first_rd = -1; rd_low = 0; cs_only = 0;
    busy_bad = 0; gap_bad = 0; hi_run = 0; prev_cs = 1'b1; first_addr = '0;
    while (!line_valid && n < 400) begin
      if (prev_cs && !mem_cs_n) begin
        if (falls > 0 && hi_run < 2) gap_bad++;
        falls++;
        if (first_cs < 0) begin
          first_cs   = n;
          first_addr = mem_addr;
        end
      end
      if (mem_cs_n) hi_run++; else hi_run = 0;
      if (!mem_rd_n) begin
        rd_low++;
        if (first_rd < 0) first_rd = n;
      end
      if (!mem_cs_n && mem_rd_n) cs_only++;
      if (req_ready) busy_bad++;
      prev_cs = mem_cs_n;
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;

    chk(first_cs == 1, "R5 chip select low at first sample", 128'(first_cs), 128'd1);
    chk(first_rd - first_cs == s_ticks, "R5 setup half cycles",
        128'(first_rd - first_cs), 128'(s_ticks));
    chk(falls == nbur, "R2/R3 burst count", 128'(falls), 128'(nbur));
    chk(gap_bad == 0, "R3 chip select gap between bursts", 128'(gap_bad), 128'd0);
    chk(cs_only == nbur * (s_ticks + 2 * wc * (bb - 1)), "R4 wait plus setup half cycles",
        128'(cs_only), 128'(nbur * (s_ticks + 2 * wc * (bb - 1))));
    chk(rd_low == 2 * tot_b, "R6 strobe low half cycles", 128'(rd_low), 128'(2 * tot_b));
    chk(first_addr == base, "R6 aligned start address", 128'(first_addr), 128'(base));
    chk(busy_bad == 0, "R9 ready low during fill", 128'(busy_bad), 128'd0);
    chk(n == t_exp + 1, "R8 done latency", 128'(n), 128'(t_exp + 1));
    chk(line_data == exp_line, "R7 assembled line", line_data, exp_line);
    @(negedge clk);
    chk(line_valid == 1'b0, "R8 done lasts one cycle", 128'(line_valid), 128'd0);
    chk(mem_cs_n == 1'b1, "R9 held request not taken", 128'(mem_cs_n), 128'd1);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_cs_n == 1'b1 && mem_rd_n == 1'b1, "R10 strobes idle in reset",
        128'({mem_cs_n, mem_rd_n}), 128'd3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready after reset", 128'(req_ready), 128'd1);
    chk(line_valid == 1'b0, "R10 no done after reset", 128'(line_valid), 128'd0);
    chk(cfg_rdata == 32'd0, "R1 config resets to zero", 128'(cfg_rdata), 128'd0);

    cfg_we = 1'b1; cfg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_rdata == 32'h0013_1800, "R1 only kept fields stored",
        128'(cfg_rdata), 128'h0013_1800);
    cfg_we = 1'b1; cfg_wdata = 32'h000C_E000;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_rdata == 32'd0, "R1 reserved bits read zero", 128'(cfg_rdata), 128'd0);

    for (int k = 0; k < 64; k++) begin
      run_one(k[0], k[1], (k >> 2) & 3, (k >> 4) & 3, 24'h012300 + 24'(k * 37 + 5));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule